// File: doc/BRIEF.md
# Single-Lane Memory-Card Data Block Receiver

This block takes one data block arriving serially on a single card data line and turns it into bytes. The line idles high. The first low bit sampled marks the start of a block. After it come the payload bytes, most significant bit first, then a 16-bit check value and a closing high bit. Each payload byte is handed out on a one-cycle valid pulse alongside an 8-bit data bus.

While the payload streams past, the block runs a 16-bit CRC over the payload bits, and only those bits. It then shifts in the transmitted check value and the closing bit. On one completion pulse it reports whether the check value matched and whether the closing bit was correct.

The frame itself carries no length, so the surrounding host logic supplies the byte count on a configuration input. That count is taken when the start bit arrives. Line sampling is gated by a bit strobe that marks each rising edge of the card clock. The receiver returns to waiting after every block, so consecutive blocks of a multi-block read arrive without any reset in between.

Top module: `sdblk_rx`

## Requirements
- R1: While waiting, a strobed high bit or any cycle with `bit_en` low produces no output and starts nothing. The first strobed low bit is taken as the start bit.
- R2: Payload bits are assembled most significant bit first. One clock after the strobe of a byte's eighth bit, `byte_valid` pulses for one cycle, and `byte_data` holds that byte until the next strobe.
- R3: The number of payload bytes equals `blk_len` as sampled in the start-bit strobe cycle. Changes to `blk_len` later in the block have no effect.
- R4: The check value is a CRC with polynomial x^16+x^12+x^5+1 (0x1021), seeded with zero, computed over the payload bits only (not the start bit). It is received most significant bit first. When it matches the computed value, `crc_err` stays 0 in the completion cycle.
- R5: When the received check value differs from the computed one, `crc_err` is 1 in the completion cycle.
- R6: A closing bit sampled as 0 sets `frame_err` in the completion cycle, and `blk_done` still pulses.
- R7: `blk_done` is a one-cycle pulse one clock after the closing bit's strobe. `crc_err` and `frame_err` are 0 in every other cycle.
- R8: A new start bit strobed directly after a closing bit begins the next block without reset.
- R9: With `blk_len` = 0, the frame is a start bit, 16 check bits (expected value 0x0000) and a closing bit, and no byte is emitted.
- R10: After reset, all outputs are 0 and the block waits for a start bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | One-cycle strobe marking a card-clock rising edge; the line is sampled only then |
| dat_in | input | 1 | Card data line |
| blk_len | input | LEN_W | Payload byte count for the next block |
| byte_valid | output | 1 | One-cycle pulse when a payload byte is complete |
| byte_data | output | 8 | Most recently assembled payload byte |
| blk_done | output | 1 | One-cycle pulse when the closing bit has been sampled |
| crc_err | output | 1 | Check value mismatch, valid with `blk_done` |
| frame_err | output | 1 | Closing bit was 0, valid with `blk_done` |

## Verification
The hardest cases to reach from the ports are a block whose framing is perfect but whose check value is wrong by a single bit, and a second block whose start bit lands on the very next strobe after a closing bit. The stimulus computes the correct check value in the bench and then flips one randomly chosen bit of it. It also sends blocks back to back with no idle strobes in between, at random gaps between strobes. One directed run changes `blk_len` in the middle of a block. Another sends a full 512-byte block of 0xFF against its known check value, 0x7FA1.

// File: rtl/sdrx_pkg.sv
package sdrx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DATA,
        ST_CRC,
        ST_STOP
    } rx_state_e;

    localparam int          CRC_W    = 16;
    localparam logic [15:0] CRC_POLY = 16'h1021;
    localparam int          BYTE_W   = 8;
endpackage

// File: rtl/sdrx_crc_acc.sv
module sdrx_crc_acc #(
    parameter int          W    = 16,
    parameter logic [15:0] POLY = 16'h1021
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    input  logic         bit_i,
    output logic [W-1:0] crc_o
);
    logic [W-1:0] crc_d, crc_q;
    logic         fb;

    always_comb begin
        fb    = crc_q[W-1] ^ bit_i;
        crc_d = crc_q;
        if (clr) begin
            crc_d = '0;
        end else if (en) begin
            crc_d = {crc_q[W-2:0], 1'b0} ^ (fb ? POLY[W-1:0] : '0);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) crc_q <= '0;
        else        crc_q <= crc_d;
    end

    assign crc_o = crc_q;
endmodule

// File: rtl/sdrx_shreg.sv
module sdrx_shreg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         bit_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = en ? {sh_q[W-2:0], bit_i} : sh_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign q_o = sh_q;
endmodule

// File: rtl/sdblk_rx.sv
module sdblk_rx
    import sdrx_pkg::*;
#(
    parameter int LEN_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_en,
    input  logic             dat_in,
    input  logic [LEN_W-1:0] blk_len,
    output logic             byte_valid,
    output logic [7:0]       byte_data,
    output logic             blk_done,
    output logic             crc_err,
    output logic             frame_err
);
    localparam int BCNT_W = $clog2(CRC_W);
    localparam logic [BCNT_W-1:0] LAST_DBIT = BCNT_W'(BYTE_W - 1);
    localparam logic [BCNT_W-1:0] LAST_CBIT = BCNT_W'(CRC_W - 1);

    typedef struct packed {
        rx_state_e         state;
        logic [BCNT_W-1:0] bit_cnt;
        logic [LEN_W-1:0]  byte_cnt;
        logic [LEN_W-1:0]  len;
        logic              byte_valid;
        logic              done;
        logic              crc_err;
        logic              frame_err;
    } rx_regs_t;

    rx_regs_t r_d, r_q;

    logic              crc_clr, crc_en, dsh_en, csh_en;
    logic [CRC_W-1:0]  crc_calc, crc_rx;
    logic [BYTE_W-1:0] dsh_q;

    sdrx_crc_acc #(.W(CRC_W), .POLY(CRC_POLY)) u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (crc_clr),
        .en    (crc_en),
        .bit_i (dat_in),
        .crc_o (crc_calc)
    );

    sdrx_shreg #(.W(BYTE_W)) u_dsh (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (dsh_en),
        .bit_i (dat_in),
        .q_o   (dsh_q)
    );

    sdrx_shreg #(.W(CRC_W)) u_csh (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (csh_en),
        .bit_i (dat_in),
        .q_o   (crc_rx)
    );

    always_comb begin
        r_d            = r_q;
        r_d.byte_valid = 1'b0;
        r_d.done       = 1'b0;
        r_d.crc_err    = 1'b0;
        r_d.frame_err  = 1'b0;
        crc_clr        = 1'b0;
        crc_en         = 1'b0;
        dsh_en         = 1'b0;
        csh_en         = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (bit_en && !dat_in) begin
                    crc_clr      = 1'b1;
                    r_d.len      = blk_len;
                    r_d.bit_cnt  = '0;
                    r_d.byte_cnt = '0;
                    r_d.state    = (blk_len == '0) ? ST_CRC : ST_DATA;
                end
            end
            ST_DATA: begin
                if (bit_en) begin
                    crc_en      = 1'b1;
                    dsh_en      = 1'b1;
                    r_d.bit_cnt = r_q.bit_cnt + 1'b1;
                    if (r_q.bit_cnt == LAST_DBIT) begin
                        r_d.bit_cnt    = '0;
                        r_d.byte_valid = 1'b1;
                        r_d.byte_cnt   = r_q.byte_cnt + 1'b1;
                        if (r_q.byte_cnt == r_q.len - LEN_W'(1)) begin
                            r_d.state = ST_CRC;
                        end
                    end
                end
            end
            ST_CRC: begin
                if (bit_en) begin
                    csh_en      = 1'b1;
                    r_d.bit_cnt = r_q.bit_cnt + 1'b1;
                    if (r_q.bit_cnt == LAST_CBIT) begin
                        r_d.bit_cnt = '0;
                        r_d.state   = ST_STOP;
                    end
                end
            end
            default: begin
                if (bit_en) begin
                    r_d.done      = 1'b1;
                    r_d.frame_err = !dat_in;
                    r_d.crc_err   = (crc_calc != crc_rx);
                    r_d.state     = ST_IDLE;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign byte_valid = r_q.byte_valid;
    assign byte_data  = dsh_q;
    assign blk_done   = r_q.done;
    assign crc_err    = r_q.crc_err;
    assign frame_err  = r_q.frame_err;
endmodule

// File: rtl/sdblk_rx_chk.sv
module sdblk_rx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bit_en,
    input logic       byte_valid,
    input logic [7:0] byte_data,
    input logic       blk_done,
    input logic       crc_err,
    input logic       frame_err
);
    assert_done_after_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        blk_done |-> $past(bit_en));

    assert_flags_only_with_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (crc_err || frame_err) |-> blk_done);

    assert_byte_after_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid |-> $past(bit_en));

    assert_byte_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bit_en) |-> $stable(byte_data));

    assert_no_byte_at_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(byte_valid && blk_done));
endmodule

bind sdblk_rx sdblk_rx_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_en     (bit_en),
    .byte_valid (byte_valid),
    .byte_data  (byte_data),
    .blk_done   (blk_done),
    .crc_err    (crc_err),
    .frame_err  (frame_err)
);

// File: tb/sim_sdblk_rx.sv
`timescale 1ns/1ps
module sim_sdblk_rx;
    localparam int LEN_W = 12;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             bit_en = 1'b0;
    logic             dat_in = 1'b1;
    logic [LEN_W-1:0] blk_len = '0;
    logic             byte_valid, blk_done, crc_err, frame_err;
    logic [7:0]       byte_data;

    int tests = 0;
    int fails = 0;
    int done_cnt = 0;
    logic last_crc_err = 1'b0;
    logic last_frame_err = 1'b0;
    logic [7:0] got_q[$];

    always #4 clk = ~clk;

    sdblk_rx #(.LEN_W(LEN_W)) u0 (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .dat_in(dat_in),
        .blk_len(blk_len), .byte_valid(byte_valid), .byte_data(byte_data),
        .blk_done(blk_done), .crc_err(crc_err), .frame_err(frame_err)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (byte_valid) got_q.push_back(byte_data);
            if (blk_done) begin
                done_cnt++;
                last_crc_err = crc_err;
                last_frame_err = frame_err;
            end
        end
    end

    function automatic logic [15:0] ref_crc(input logic [7:0] d[$]);
        logic [15:0] c = 16'h0000;
        foreach (d[i]) begin
            for (int b = 7; b >= 0; b--) begin
                logic top = c[15] ^ d[i][b];
                c = {c[14:0], 1'b0};
                if (top) c = c ^ 16'h1021;
            end
        end
        return c;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic send_bit(input logic b, input int gap);
        dat_in = b;
        bit_en = 1'b1;
        @(negedge clk);
        bit_en = 1'b0;
        for (int k = 1; k < gap; k++) begin
            dat_in = 1'($urandom);
            @(negedge clk);
        end
    endtask

    function automatic int pick_gap(input int maxgap);
        return 1 + int'($urandom % maxgap);
    endfunction

    task automatic send_frame(input logic [7:0] d[$], input logic [LEN_W-1:0] len_after,
                              input logic [15:0] crc_flip, input logic stop_v, input int maxgap);
        logic [15:0] c = ref_crc(d) ^ crc_flip;
        blk_len = LEN_W'(d.size());
        send_bit(1'b0, pick_gap(maxgap));
        blk_len = len_after;
        foreach (d[i])
            for (int b = 7; b >= 0; b--) send_bit(d[i][b], pick_gap(maxgap));
        for (int b = 15; b >= 0; b--) send_bit(c[b], pick_gap(maxgap));
        send_bit(stop_v, pick_gap(maxgap));
        dat_in = 1'b1;
    endtask

    task automatic check_frame(input logic [7:0] exp_q[$], input int dones_before,
                               input logic exp_ce, input logic exp_fe, input string tag);
        repeat (3) @(negedge clk);
        check(got_q.size() == exp_q.size(), {tag, " R3 byte count"}, got_q.size(), exp_q.size());
        foreach (exp_q[i])
            if (i < got_q.size())
                check(got_q[i] == exp_q[i], {tag, " R2 byte value"}, got_q[i], exp_q[i]);
        check(done_cnt == dones_before + 1, {tag, " R7 done pulse count"}, done_cnt, dones_before + 1);
        check(last_crc_err == exp_ce, {tag, " R4/R5 crc_err"}, last_crc_err, exp_ce);
        check(last_frame_err == exp_fe, {tag, " R6 frame_err"}, last_frame_err, exp_fe);
        got_q.delete();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=0x0 expected=0x1");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [7:0] d[$];
        logic [7:0] e[$];
        int dc;
        void'($urandom(32'h5D0C_1A7E));
        repeat (4) @(negedge clk);
        // R10 reset state
        check({byte_valid, blk_done, crc_err, frame_err} == 4'b0, "R10 outputs in reset",
              {byte_valid, blk_done, crc_err, frame_err}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check({byte_valid, byte_data, blk_done, crc_err, frame_err} == '0, "R10 outputs after reset",
              {byte_valid, byte_data, blk_done, crc_err, frame_err}, 0);

        // R1 idle high bits and unstrobed low levels do nothing
        dc = done_cnt;
        for (int i = 0; i < 12; i++) send_bit(1'b1, 3);
        dat_in = 1'b0;
        repeat (10) @(negedge clk);
        dat_in = 1'b1;
        repeat (3) @(negedge clk);
        check(got_q.size() == 0 && done_cnt == dc, "R1 idle produces no output", got_q.size() + done_cnt - dc, 0);

        // R4 directed known vector: 512 bytes of 0xFF has check value 0x7FA1
        d.delete();
        for (int i = 0; i < 512; i++) d.push_back(8'hFF);
        check(ref_crc(d) == 16'h7FA1, "R4 bench reference vector", ref_crc(d), 16'h7FA1);
        dc = done_cnt;
        send_frame(d, LEN_W'(512), 16'h0, 1'b1, 1);
        check_frame(d, dc, 1'b0, 1'b0, "R4 full 512-byte block");

        // R9 zero-length block
        d.delete();
        dc = done_cnt;
        send_frame(d, '0, 16'h0, 1'b1, 2);
        check_frame(d, dc, 1'b0, 1'b0, "R9 zero-length block");

        // R3 length changed after start bit is ignored
        d = '{8'hA5, 8'h3C, 8'h81};
        dc = done_cnt;
        send_frame(d, LEN_W'(1), 16'h0, 1'b1, 2);
        check_frame(d, dc, 1'b0, 1'b0, "R3 mid-block length change");

        // R5 single-bit check value error
        d = '{8'h00, 8'h7E};
        dc = done_cnt;
        send_frame(d, LEN_W'(2), 16'h0100, 1'b1, 1);
        check_frame(d, dc, 1'b1, 1'b0, "R5 corrupted check value");

        // R6 closing bit low
        d = '{8'h12};
        dc = done_cnt;
        send_frame(d, LEN_W'(1), 16'h0, 1'b0, 1);
        check_frame(d, dc, 1'b0, 1'b1, "R6 bad closing bit");

        // R8 back-to-back blocks with no idle strobe between
        d = '{8'hDE, 8'hAD};
        e = '{8'hBE, 8'hEF, 8'h01};
        dc = done_cnt;
        send_frame(d, LEN_W'(2), 16'h0, 1'b1, 1);
        send_frame(e, LEN_W'(3), 16'h0, 1'b1, 1);
        repeat (3) @(negedge clk);
        check(done_cnt == dc + 2, "R8 two completions", done_cnt, dc + 2);
        check(got_q.size() == 5, "R8 bytes of both blocks", got_q.size(), 5);
        if (got_q.size() == 5)
            check(got_q[2] == 8'hBE && got_q[4] == 8'h01, "R8 second block bytes", {got_q[2], got_q[4]}, 16'hBE01);
        check(last_crc_err == 1'b0 && last_frame_err == 1'b0, "R8 second block clean",
              {last_crc_err, last_frame_err}, 0);
        got_q.delete();

        // Random blocks: R2 R3 R4 R5 R6 R7
        for (int n = 0; n < 30; n++) begin
            int len = 1 + int'($urandom % 40);
            int kind = int'($urandom % 3);
            logic [15:0] flip = (kind == 1) ? (16'h1 << ($urandom % 16)) : 16'h0;
            d.delete();
            for (int i = 0; i < len; i++) d.push_back(8'($urandom));
            for (int i = 0; i < int'($urandom % 3); i++) send_bit(1'b1, 2);
            dc = done_cnt;
            send_frame(d, LEN_W'($urandom), flip, (kind == 2) ? 1'b0 : 1'b1, 3);
            check_frame(d, dc, kind == 1, kind == 2, "R2 random block");
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule